// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer ALU assembled from a row of identical one-bit slices, with a distinct slice in the most significant position. It takes two operands and a three-bit control word. It returns a result word, a flag that is high when the result is all zeros, and a signed overflow flag. The control word has two fields. The first is a negate flag, which inverts the second operand and also supplies the carry into bit 0. The second is a two-bit selector that picks the per-slice output.

Subtraction and signed less-than both run through the same ripple adder. For less-than, the top slice forms a "set" bit from the sign of the difference, corrected by the overflow flag, and this bit is steered into the lowest slice. Every other slice sees a constant zero in that position.

The operand width is a parameter. Two variants are chosen at elaboration. The overflow logic can use either a sign comparison or a carry comparison, and zero detection can use either one flat reduction or a grouped two-level tree.

Top module: `alu_rippled`

## Requirements
- R1: With ctrl = 3'b000 (ctrl[2] is the negate flag, ctrl[1:0] is the selector), the result is the bitwise AND of op_a and op_b.
- R2: With ctrl = 3'b001, the result is the bitwise OR of op_a and op_b.
- R3: With ctrl = 3'b010, the result is op_a + op_b modulo 2^WIDTH.
- R4: With ctrl = 3'b110, the result is op_a - op_b modulo 2^WIDTH, formed as op_a + ~op_b + 1.
- R5: With ctrl = 3'b111, the result is 1 when op_a < op_b as two's-complement signed values and 0 otherwise. This holds across the whole signed range, including pairs whose difference overflows. All result bits above bit 0 are zero.
- R6: With ctrl = 3'b010, overflow is high exactly when the true signed sum of op_a and op_b lies outside the signed WIDTH-bit range.
- R7: With ctrl = 3'b110 or 3'b111, overflow is high exactly when the true signed difference op_a - op_b lies outside the signed WIDTH-bit range.
- R8: zero is high exactly when every bit of result is 0, for every control value.
- R9: All outputs settle combinationally from the inputs, with no clock or stored state. The same requirements hold for any WIDTH of 2 or more, under either overflow variant and either zero-detect variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, inverted when the negate flag is set |
| ctrl | input | 3 | Control: bit 2 is the negate flag, bits 1:0 are the selector (00 AND, 01 OR, 10 sum, 11 less) |
| result | output | WIDTH | Selected result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the adder path |

## Verification
The bench builds two instances. The first uses the default 32-bit width with sign-based overflow and flat zero detection. The second is 8 bits wide and uses the carry-based overflow variant with grouped zero detection. At 8 bits, random operands hit the signed extremes, overflow on add and subtract, and less-than across the overflow boundary often, rather than almost never. This brings both generate variants under the same checks. Directed vectors add the most negative and most positive operands, equal operands, and the minus-one cases at both widths.

// File: rtl/alu_pkg.sv
package alu_pkg;

   // Selector field of the control word; the slice mux depends on this order.
   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } sel_e;

   typedef struct packed {
      logic negate;
      sel_e sel;
   } ctrl_t;

   localparam int CTRL_W = 3;

   // Overflow variant selection
   localparam int OVF_BY_SIGN  = 0;
   localparam int OVF_BY_CARRY = 1;

   // Zero detect variant selection
   localparam int ZERO_FLAT    = 0;
   localparam int ZERO_GROUPED = 1;

   function automatic logic slice_pick(input sel_e sel, input logic a,
                                       input logic b_eff, input logic sum,
                                       input logic less);
      logic r;
      case (sel)
         SEL_AND:  r = a & b_eff;
         SEL_OR:   r = a | b_eff;
         SEL_SUM:  r = sum;
         default:  r = less;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
   import alu_pkg::*;
(
   input  logic a,
   input  logic b,
   input  logic negate,
   input  logic cin,
   input  logic less,
   input  sel_e sel,
   output logic res,
   output logic cout
);

   logic b_eff;
   logic sum;

   assign b_eff = b ^ negate;
   assign sum   = a ^ b_eff ^ cin;
   assign cout  = (a & b_eff) | (cin & (a ^ b_eff));
   assign res   = slice_pick(sel, a, b_eff, sum, 1'b0) | ((sel == SEL_LESS) & less);

endmodule

// File: rtl/alu_top_slice.sv
module alu_top_slice
   import alu_pkg::*;
#(
   parameter int OVF_MODE = OVF_BY_SIGN
) (
   input  logic a,
   input  logic b,
   input  logic negate,
   input  logic cin,
   input  sel_e sel,
   output logic res,
   output logic set_out,
   output logic ovf
);

   logic b_eff;
   logic sum;

   assign b_eff = b ^ negate;
   assign sum   = a ^ b_eff ^ cin;

   generate
      if (OVF_MODE == OVF_BY_CARRY) begin : g_ovf_carry
         logic cout;
         assign cout = (a & b_eff) | (cin & (a ^ b_eff));
         assign ovf  = cin ^ cout;
      end else begin : g_ovf_sign
         assign ovf = (a == b_eff) && (sum != a);
      end
   endgenerate

   // Sign of the difference, corrected when it overflowed
   assign set_out = sum ^ ovf;

   // The less input of the top slice is tied low
   assign res = slice_pick(sel, a, b_eff, sum, 1'b0);

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect
   import alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int STYLE = ZERO_FLAT,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] vec,
   output logic             is_zero
);

   generate
      if (STYLE == ZERO_GROUPED) begin : g_grouped
         localparam int GROUPS = (WIDTH + GROUP - 1) / GROUP;
         localparam int PADDED = GROUPS * GROUP;
         logic [PADDED-1:0] padded;
         logic [GROUPS-1:0] any_set;

         always_comb begin
            padded             = '0;
            padded[WIDTH-1:0]  = vec;
         end

         for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            assign any_set[g] = |padded[g*GROUP +: GROUP];
         end

         assign is_zero = ~|any_set;
      end else begin : g_flat
         assign is_zero = ~|vec;
      end
   endgenerate

endmodule

// File: rtl/alu_rippled.sv
module alu_rippled
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int OVF_MODE   = OVF_BY_SIGN,
   parameter int ZERO_STYLE = ZERO_FLAT,
   parameter int ZERO_GROUP = 4
) (
   input  logic [WIDTH-1:0]  op_a,
   input  logic [WIDTH-1:0]  op_b,
   input  logic [CTRL_W-1:0] ctrl,
   output logic [WIDTH-1:0]  result,
   output logic              zero,
   output logic              overflow
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_rippled: WIDTH must be at least 2");
      end
      if (OVF_MODE != OVF_BY_SIGN && OVF_MODE != OVF_BY_CARRY) begin : g_bad_ovf
         $error("alu_rippled: OVF_MODE out of range");
      end
      if (ZERO_STYLE != ZERO_FLAT && ZERO_STYLE != ZERO_GROUPED) begin : g_bad_zero
         $error("alu_rippled: ZERO_STYLE out of range");
      end
      if (ZERO_GROUP < 1) begin : g_bad_group
         $error("alu_rippled: ZERO_GROUP must be positive");
      end
   endgenerate

   ctrl_t      c;
   logic [MSB:0] carry;
   logic         set_bit;

   assign c        = ctrl_t'(ctrl);
   assign carry[0] = c.negate;

   generate
      for (genvar i = 0; i < MSB; i++) begin : g_slice
         alu_slice u_slice (
            .a      (op_a[i]),
            .b      (op_b[i]),
            .negate (c.negate),
            .cin    (carry[i]),
            .less   ((i == 0) ? set_bit : 1'b0),
            .sel    (c.sel),
            .res    (result[i]),
            .cout   (carry[i+1])
         );
      end
   endgenerate

   alu_top_slice #(
      .OVF_MODE (OVF_MODE)
   ) u_top (
      .a       (op_a[MSB]),
      .b       (op_b[MSB]),
      .negate  (c.negate),
      .cin     (carry[MSB]),
      .sel     (c.sel),
      .res     (result[MSB]),
      .set_out (set_bit),
      .ovf     (overflow)
   );

   alu_zero_detect #(
      .WIDTH (WIDTH),
      .STYLE (ZERO_STYLE),
      .GROUP (ZERO_GROUP)
   ) u_zero (
      .vec     (result),
      .is_zero (zero)
   );

endmodule

// File: rtl/alu_rippled_chk.sv
module alu_rippled_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [2:0]       ctrl,
   input logic [WIDTH-1:0] result,
   input logic             zero,
   input logic             overflow
);

   logic signed [WIDTH:0] wide_add;
   logic signed [WIDTH:0] wide_sub;
   logic                  ref_add_ovf;
   logic                  ref_sub_ovf;
   logic                  ref_less;

   always_comb begin
      wide_add    = $signed({op_a[WIDTH-1], op_a}) + $signed({op_b[WIDTH-1], op_b});
      wide_sub    = $signed({op_a[WIDTH-1], op_a}) - $signed({op_b[WIDTH-1], op_b});
      ref_add_ovf = wide_add[WIDTH] != wide_add[WIDTH-1];
      ref_sub_ovf = wide_sub[WIDTH] != wide_sub[WIDTH-1];
      ref_less    = wide_sub[WIDTH];
   end

   always_comb begin
      if (ctrl == 3'b000) begin
         assert_and_R1: assert (result == (op_a & op_b))
            else $error("R1 AND result mismatch");
      end
      if (ctrl == 3'b010) begin
         assert_add_R3: assert (result == wide_add[WIDTH-1:0])
            else $error("R3 sum mismatch");
         assert_add_ovf_R6: assert (overflow == ref_add_ovf)
            else $error("R6 add overflow mismatch");
      end
      if (ctrl == 3'b111) begin
         assert_less_R5: assert (result == {{(WIDTH-1){1'b0}}, ref_less})
            else $error("R5 less-than mismatch");
      end
      if (ctrl == 3'b110 || ctrl == 3'b111) begin
         assert_sub_ovf_R7: assert (overflow == ref_sub_ovf)
            else $error("R7 subtract overflow mismatch");
      end
      assert_zero_R8: assert (zero == (result == '0))
         else $error("R8 zero flag mismatch");
   end

endmodule

bind alu_rippled alu_rippled_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a     (op_a),
   .op_b     (op_b),
   .ctrl     (ctrl),
   .result   (result),
   .zero     (zero),
   .overflow (overflow)
);

// File: tb/tb_alu_rippled.sv
module tb_alu_rippled;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [31:0] a, b;
   logic [2:0]  ctrl;
   logic [31:0] res32;
   logic [7:0]  res8;
   logic        zero32, zero8, ovf32, ovf8;

   alu_rippled dut (
      .op_a(a), .op_b(b), .ctrl(ctrl),
      .result(res32), .zero(zero32), .overflow(ovf32)
   );

   alu_rippled #(.WIDTH(8), .OVF_MODE(1), .ZERO_STYLE(1), .ZERO_GROUP(3)) dut8 (
      .op_a(a[7:0]), .op_b(b[7:0]), .ctrl(ctrl),
      .result(res8), .zero(zero8), .overflow(ovf8)
   );

   function automatic longint sext(logic [31:0] v, int w);
      longint r = longint'(v & ((64'd1 << w) - 1));
      if (v[w-1]) r = r - (longint'(1) << w);
      return r;
   endfunction

   function automatic logic [31:0] exp_res(logic [31:0] x, logic [31:0] y, logic [2:0] c, int w);
      longint sa = sext(x, w), sb = sext(y, w);
      logic [63:0] m = (64'd1 << w) - 1;
      logic [63:0] r;
      case (c)
         3'b000:  r = {32'd0, x & y};
         3'b001:  r = {32'd0, x | y};
         3'b010:  r = 64'(sa + sb);
         3'b110:  r = 64'(sa - sb);
         default: r = (sa < sb) ? 64'd1 : 64'd0;
      endcase
      return 32'(r & m);
   endfunction

   function automatic logic exp_ovf(logic [31:0] x, logic [31:0] y, logic [2:0] c, int w);
      longint sa = sext(x, w), sb = sext(y, w);
      longint t  = (c == 3'b010) ? sa + sb : sa - sb;
      longint hi = (longint'(1) << (w - 1)) - 1;
      longint lo = -(longint'(1) << (w - 1));
      return (t > hi) || (t < lo);
   endfunction

   function automatic string req_of(logic [2:0] c);
      case (c)
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b010:  return "R3";
         3'b110:  return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s a=%h b=%h ctrl=%b actual=%h expected=%h", req, a, b, ctrl, act, exp);
      end
   endtask

   // Drive one vector after a rising edge, sample on the falling edge.
   task automatic apply(logic [31:0] x, logic [31:0] y, logic [2:0] c);
      logic [31:0] e32, e8;
      @(posedge clk);
      a = x; b = y; ctrl = c;
      @(negedge clk);
      e32 = exp_res(x, y, c, 32);
      e8  = exp_res(x, y, c, 8);
      check({req_of(c), " w32"}, res32, e32);
      check({req_of(c), " w8"}, {24'd0, res8}, e8);
      check("R8 w32", {31'd0, zero32}, {31'd0, e32 == 0});
      check("R8 w8", {31'd0, zero8}, {31'd0, e8 == 0});
      if (c == 3'b010) begin
         check("R6 w32", {31'd0, ovf32}, {31'd0, exp_ovf(x, y, c, 32)});
         check("R6 w8", {31'd0, ovf8}, {31'd0, exp_ovf(x, y, c, 8)});
      end else if (c == 3'b110 || c == 3'b111) begin
         check("R7 w32", {31'd0, ovf32}, {31'd0, exp_ovf(x, y, c, 32)});
         check("R7 w8", {31'd0, ovf8}, {31'd0, exp_ovf(x, y, c, 8)});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [2:0] ops [5];
      logic [31:0] seedv;
      ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
      a = '0; b = '0; ctrl = 3'b000;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // Idle state: zero operands, AND selected (R9: no state, settles directly)
      check("R9 idle result", res32, 32'd0);
      check("R9 idle zero", {31'd0, zero32}, 32'd1);

      // Directed corners
      apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010); // add overflow w32, R6
      apply(32'h8000_0000, 32'hFFFF_FFFF, 3'b010); // negative overflow
      apply(32'h0000_007F, 32'h0000_0001, 3'b010); // w8 overflow
      apply(32'h8000_0000, 32'h0000_0001, 3'b110); // sub overflow R7
      apply(32'h1234_5678, 32'h1234_5678, 3'b110); // equal: zero R4 R8
      apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111); // min < max across overflow R5
      apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111); // max not < min
      apply(32'h0000_0080, 32'h0000_007F, 3'b111); // w8 boundary
      apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111); // -1 < 0
      apply(32'h5555_5555, 32'h5555_5555, 3'b111); // equal, not less
      apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b000); // disjoint AND R1
      apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b001); // full OR R2
      apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010); // wrap to zero R3

      // Constrained random
      seedv = $urandom(32'd1234);
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] x, y;
         x = $urandom();
         y = $urandom();
         case ($urandom_range(0, 3))
            0: x = {x[31], 31'h7FFF_FFFF ^ {31{x[30]}}};
            1: y = x;
            default: ;
         endcase
         apply(x, y, ops[$urandom_range(0, 4)]);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule